// File: doc/BRIEF.md
# Single-Level Return Stack with Carry

This block keeps one return address for a small 4-bit processor core, together with one saved carry bit. The core pulses one of two push requests when it leaves the running code: interrupt entry or subroutine call. It pulses one of two pop requests when it comes back: return from interrupt or plain return. The stored program counter is always visible on `pc_out`. A one-cycle `pc_load` strobe tells the core to take it.

The carry flag travels only on the interrupt path. Interrupt entry saves the live carry. Return from interrupt raises `carry_load`, so the core restores its carry from `carry_out`. A subroutine call leaves the stored carry alone. A plain return keeps `carry_load` low, so the core's own carry survives.

With a single entry, every push overwrites the previous contents and no overflow is reported. A pop reads the entry without clearing it.

Top module: `ret_stack1`

## Requirements
- R1: After reset, `pc_out` is 0, `carry_out` is 0, and with no request asserted both `pc_load` and `carry_load` are low.
- R2: When `irq_push` is high at a clock edge, `pc_out` equals the sampled `pc_in` and `carry_out` equals the sampled `carry_in` from the next cycle on.
- R3: When `call_push` is high and `irq_push` is low at an edge, `pc_out` takes `pc_in` and `carry_out` keeps its previous value.
- R4: In a cycle with `reti_pop` high and no push request, `pc_load` and `carry_load` are both 1, and `pc_out`/`carry_out` show the stored entry.
- R5: In a cycle with `ret_pop` high, `reti_pop` low and no push request, `pc_load` is 1 and `carry_load` is 0.
- R6: A second push before any pop replaces the stored entry, and the first value is lost without any indication.
- R7: When a push and a pop request are high in the same cycle, the push is performed and both `pc_load` and `carry_load` stay low.
- R8: When `irq_push` and `call_push` are both high, the interrupt form wins and the carry is saved.
- R9: A pop leaves the stored PC and carry unchanged.
- R10: With no request high, both strobes are low and the stored entry holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_push | input | 1 | Interrupt entry: save PC and carry |
| call_push | input | 1 | Subroutine call: save PC only |
| ret_pop | input | 1 | Plain return request |
| reti_pop | input | 1 | Return-from-interrupt request |
| pc_in | input | PC_W (13) | Current program counter |
| carry_in | input | 1 | Current carry flag |
| pc_out | output | PC_W (13) | Stored return address |
| carry_out | output | 1 | Stored carry bit |
| pc_load | output | 1 | Return-valid strobe for `pc_out` |
| carry_load | output | 1 | Carry-restore strobe for `carry_out` |

## Verification
The bench runs through every combination of the four request lines, with both carry values and many PC values. A bench-side model of the single entry supplies the expected results.

Each corner case has a typical failure:
- Call path: a design that saved the carry on a call would corrupt the carry that an interrupted routine later restores.
- Plain return: a design that raised `carry_load` on a plain return would clobber the core's live carry.
- Push and pop in the same cycle: a design that let the pop win would return to a stale address while losing the new one.
- Back-to-back pushes and repeated pops: these show whether the entry is overwritten or wrongly cleared.

// File: rtl/ret_stack1.sv
module ret_stack1 #(
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_push,
  input  logic            call_push,
  input  logic            ret_pop,
  input  logic            reti_pop,
  input  logic [PC_W-1:0] pc_in,
  input  logic            carry_in,
  output logic [PC_W-1:0] pc_out,
  output logic            carry_out,
  output logic            pc_load,
  output logic            carry_load
);

  logic [PC_W-1:0] slot_pc;
  logic            slot_c;
  logic            any_push;

  assign any_push = irq_push | call_push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_pc <= '0;
      slot_c  <= 1'b0;
    end else if (any_push) begin
      slot_pc <= pc_in;
      if (irq_push) slot_c <= carry_in;
    end
  end

  assign pc_out     = slot_pc;
  assign carry_out  = slot_c;
  assign pc_load    = ~any_push & (ret_pop | reti_pop);
  assign carry_load = ~any_push & reti_pop;

endmodule

module ret_stack1_chk #(
  parameter int PC_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_push,
  input logic            call_push,
  input logic            ret_pop,
  input logic            reti_pop,
  input logic [PC_W-1:0] pc_in,
  input logic            carry_in,
  input logic [PC_W-1:0] pc_out,
  input logic            carry_out,
  input logic            pc_load,
  input logic            carry_load
);

  AST_IRQ_SAVES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_push |=> (pc_out == $past(pc_in)) && (carry_out == $past(carry_in))); // R2

  AST_CALL_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (call_push && !irq_push) |=> (pc_out == $past(pc_in)) && (carry_out == $past(carry_out))); // R3

  AST_RETI_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_pop && !irq_push && !call_push) |-> (pc_load && carry_load)); // R4

  AST_RET_PC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pop && !reti_pop && !irq_push && !call_push) |-> (pc_load && !carry_load)); // R5

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_push || call_push) |-> (!pc_load && !carry_load)); // R7

  AST_POP_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_push && !call_push) |=> ($stable(pc_out) && $stable(carry_out))); // R9

  AST_CARRY_NEEDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    carry_load |-> pc_load); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_push && !call_push && !ret_pop && !reti_pop) |-> (!pc_load && !carry_load)); // R10

endmodule

bind ret_stack1 ret_stack1_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_ret_stack1.sv
`timescale 1ns/1ps
module sim_ret_stack1;
  localparam int PC_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_push = 1'b0, call_push = 1'b0, ret_pop = 1'b0, reti_pop = 1'b0;
  logic [PC_W-1:0] pc_in = '0;
  logic carry_in = 1'b0;
  logic [PC_W-1:0] pc_out;
  logic carry_out, pc_load, carry_load;

  int checks = 0;
  int errors = 0;
  logic [PC_W-1:0] m_pc = '0;
  logic m_c = 1'b0;
  string state_tag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  ret_stack1 #(.PC_W(PC_W)) u0 (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic i, input logic c, input logic r, input logic ri,
                      input logic cy, input logic [PC_W-1:0] pc);
    logic push, pop;
    string stb_tag;
    @(negedge clk);
    irq_push = i; call_push = c; ret_pop = r; reti_pop = ri;
    carry_in = cy; pc_in = pc;
    #1;
    push = i | c;
    pop  = r | ri;
    chk(state_tag, "pc_out", int'(pc_out), int'(m_pc));
    chk(state_tag, "carry_out", int'(carry_out), int'(m_c));
    if (push && pop) stb_tag = "R7";
    else if (push) stb_tag = "R7";
    else if (ri) stb_tag = "R4";
    else if (r) stb_tag = "R5";
    else stb_tag = "R10";
    chk(stb_tag, "pc_load", int'(pc_load), int'(!push && pop));
    chk(stb_tag, "carry_load", int'(carry_load), int'(!push && ri));
    @(posedge clk);
    if (push) begin
      m_pc = pc;
      if (i) m_c = cy;
    end
    if (push && pop) state_tag = "R7";
    else if (i && c) state_tag = "R8";
    else if (i) state_tag = "R2";
    else if (c) state_tag = "R3";
    else if (pop) state_tag = "R9";
    else state_tag = "R10";
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "pc_out reset", int'(pc_out), 0);
    chk("R1", "carry_out reset", int'(carry_out), 0);
    chk("R1", "pc_load reset", int'(pc_load), 0);
    chk("R1", "carry_load reset", int'(carry_load), 0);

    for (int k = 0; k < 512; k++) begin
      logic [PC_W-1:0] p;
      p = PC_W'((k * 797 + 5) % (1 << PC_W));
      step(k[0], k[1], k[2], k[3], k[4], p);
    end

    step(1, 0, 0, 0, 1, 13'h1234);
    state_tag = "R6";
    step(0, 1, 0, 0, 0, 13'h0abc);
    state_tag = "R6";
    step(1, 0, 0, 0, 0, 13'h1fff);
    state_tag = "R6";
    step(0, 0, 0, 0, 1, 13'h0000);
    chk("R6", "overwrite pc", int'(pc_out), 13'h1fff);
    chk("R6", "overwrite carry", int'(carry_out), 0);

    step(0, 1, 0, 0, 1, 13'h0555);
    step(0, 0, 1, 0, 0, 13'h0000);
    step(0, 0, 1, 0, 0, 13'h0000);
    step(0, 0, 0, 1, 0, 13'h0000);
    step(0, 0, 0, 0, 0, 13'h0000);
    chk("R9", "pc after pops", int'(pc_out), 13'h0555);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule